// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block decides how deeply a processor subsystem powers down when its core reports that it is sleeping. Software programs a five-bit set of permission bits, one for each low-power depth, along with a requested power mode and a clock-gating mode. Both settings are thermometer-coded. The permission bits and the clock-gating mode each have their own sticky lock.

When the core's sleeping indication rises and the requested mode is permitted, the block drives the requested power level and the clock-gating level on registered, thermometer-coded outputs. It then holds them until a wakeup event arrives. On wakeup the gating is released in one cycle and the wakeup cause vector is captured. A sticky flag records that the core clock was gated; software clears it by writing a 1. The clock-gating mode used for the most recent entry can be read back.

Top module: `lpm_entry_ctrl`

Register map (`addr`, 16-bit data):
- 0, permit: bits [4:0] are the permissions for Sleep, Deep Sleep, Power Down, Deep Power Down and Hold, in that order. Bit 15 is the lock.
- 1, requested mode: bits [4:0].
- 2, clock mode: bits [2:0]. Bit 15 is the lock.
- 3, status: bit 0 is the gated flag (write 1 to clear), bits [5:1] are the wakeup cause and bits [8:6] are the last clock mode.

## Requirements
- R1: After reset all register fields read 0, both locks are clear, and `pwr_state` and `clk_gate` are 0.
- R2: A write to address 0 updates permissions [4:0] and can set the lock (bit 15). Once the lock is set, later writes to address 0 change nothing until reset.
- R3: Once the clock-mode lock (address 2, bit 15) is set, later writes to address 2 change nothing until reset.
- R4: Power-mode codes are 0x00 Active, 0x01 Sleep, 0x03 Deep Sleep, 0x07 Power Down, 0x0F Deep Power Down and 0x1F Hold. Clock codes are 0x0 none, 0x1 core, 0x3 core and platform, and 0x7 all system clocks. A write of any value that is not a thermometer code is ignored.
- R5: A rising edge on `core_sleeping` with a permitted mode drives `pwr_state` to the requested mode and `clk_gate` to the clock mode on the next cycle. The same edge captures the clock mode into status [8:6] and clears the cause field.
- R6: If the requested mode is Active, or its permission bit is clear, the sleep request is ignored and the outputs stay 0.
- R7: Entry happens only on a rising edge of `core_sleeping`. If the level stays high after a wakeup, the block does not re-enter.
- R8: While asleep, any nonzero `wake_evt` returns both outputs to 0 on the next cycle and stores the vector in status [5:1]. The bits are: 0 reset interrupt or power-down exit, 1 debug, 2 interrupt, 3 DMA, 4 external wakeup unit. The cause is held until the next entry.
- R9: The gated flag is set on the wakeup cycle when the entry gated the core clock (`clk_gate` bit 0). Writing 1 to status bit 0 clears it. A set in the same cycle overrides the clear.
- R10: Status [8:6] holds the clock mode of the last successful entry. A refused request leaves it unchanged.
- R11: Register writes made while asleep do not change `pwr_state` or `clk_gate` until the wakeup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| core_sleeping | input | 1 | Core sleeping indication |
| wake_evt | input | 5 | Wakeup event vector |
| pwr_state | output | 5 | Thermometer power level in force |
| clk_gate | output | 3 | Thermometer gating: core, platform, system |

## Verification
Two events can land in the same cycle: a wakeup that sets the gated flag, and a software write-1 that clears it. The bench first clears the flag. It then enters a sleep that gates the core clock, and in one cycle drives a wakeup vector together with a status write of 1. The flag must read 1 afterwards; a clear that won would leave 0. A clock-mode write issued during sleep is also checked against the outputs, which must keep the values latched at entry.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [0:0] {
    ST_AWAKE = 1'b0,
    ST_DOZE  = 1'b1
  } lpm_state_e;

  localparam int unsigned CHK_W  = 16;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_PERMIT = 2'd0;
  localparam logic [ADDR_W-1:0] A_PMODE  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CKMODE = 2'd2;
  localparam logic [ADDR_W-1:0] A_STATUS = 2'd3;

  // true when v is 0 or a run of ones from bit 0
  function automatic logic therm_ok(input logic [CHK_W-1:0] v);
    return ((v & (v + 1'b1)) == '0);
  endfunction

endpackage

// File: rtl/lpm_cfg_regs.sv
module lpm_cfg_regs
  import lpm_pkg::*;
#(
  parameter int unsigned NUM_MODES = 5,
  parameter int unsigned CLK_LVLS  = 3,
  parameter int unsigned DATA_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [NUM_MODES-1:0] allow_q,
  output logic                 allow_lock,
  output logic [NUM_MODES-1:0] req_mode,
  output logic [CLK_LVLS-1:0]  ck_mode,
  output logic                 ck_lock,
  output logic                 flag_clr
);

  localparam int unsigned LOCK_BIT = DATA_W - 1;

  logic wr_permit, wr_pmode, wr_ckmode;
  logic pm_code_ok, ck_code_ok;
  logic allow_lock_d, ck_lock_d;
  logic [NUM_MODES-1:0] req_mode_d;
  logic [CLK_LVLS-1:0]  ck_mode_d;
  logic unused_wdata;

  assign unused_wdata = ^wdata;

  assign pm_code_ok = therm_ok({{(CHK_W-NUM_MODES){1'b0}}, wdata[NUM_MODES-1:0]});
  assign ck_code_ok = therm_ok({{(CHK_W-CLK_LVLS){1'b0}}, wdata[CLK_LVLS-1:0]});

  assign wr_permit = wr_en && (addr == A_PERMIT) && !allow_lock;
  assign wr_pmode  = wr_en && (addr == A_PMODE) && pm_code_ok;
  assign wr_ckmode = wr_en && (addr == A_CKMODE) && !ck_lock && ck_code_ok;
  assign flag_clr  = wr_en && (addr == A_STATUS) && wdata[0];

  // permission bits: one enabled flop per mode
  for (genvar i = 0; i < NUM_MODES; i++) begin : g_allow
    logic bit_q, bit_d;
    always_comb begin
      bit_d = bit_q;
      if (wr_permit) bit_d = wdata[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= bit_d;
    end
    assign allow_q[i] = bit_q;
  end

  always_comb begin
    allow_lock_d = allow_lock;
    req_mode_d   = req_mode;
    ck_mode_d    = ck_mode;
    ck_lock_d    = ck_lock;
    if (wr_permit) allow_lock_d = wdata[LOCK_BIT];
    if (wr_pmode)  req_mode_d   = wdata[NUM_MODES-1:0];
    if (wr_ckmode) begin
      ck_mode_d = wdata[CLK_LVLS-1:0];
      ck_lock_d = wdata[LOCK_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      allow_lock <= 1'b0;
      req_mode   <= '0;
      ck_mode    <= '0;
      ck_lock    <= 1'b0;
    end else begin
      allow_lock <= allow_lock_d;
      req_mode   <= req_mode_d;
      ck_mode    <= ck_mode_d;
      ck_lock    <= ck_lock_d;
    end
  end

endmodule

// File: rtl/lpm_mode_check.sv
module lpm_mode_check #(
  parameter int unsigned NUM_MODES = 5
) (
  input  logic [NUM_MODES-1:0] allow_q,
  input  logic [NUM_MODES-1:0] req_mode,
  output logic                 permit
);

  // mode with i+1 ones in a row needs permission bit i; Active matches none
  always_comb begin
    permit = 1'b0;
    for (int i = 0; i < NUM_MODES; i++) begin
      if (req_mode == NUM_MODES'((1 << (i + 1)) - 1)) permit = allow_q[i];
    end
  end

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int unsigned NUM_MODES = 5,
  parameter int unsigned NUM_WAKE  = 5,
  parameter int unsigned CLK_LVLS  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 core_sleeping,
  input  logic [NUM_WAKE-1:0]  wake_evt,
  input  logic                 permit,
  input  logic [NUM_MODES-1:0] req_mode,
  input  logic [CLK_LVLS-1:0]  ck_mode,
  input  logic                 flag_clr,
  output logic [NUM_MODES-1:0] pwr_q,
  output logic [CLK_LVLS-1:0]  gate_q,
  output logic                 flag_q,
  output logic [NUM_WAKE-1:0]  cause_q,
  output logic [CLK_LVLS-1:0]  last_q
);

  lpm_state_e state_q, state_d;
  logic slp_q;
  logic rise, flag_set;
  logic flag_d;
  logic [NUM_MODES-1:0] pwr_d;
  logic [CLK_LVLS-1:0]  gate_d, last_d;
  logic [NUM_WAKE-1:0]  cause_d;

  assign rise = core_sleeping && !slp_q;

  always_comb begin
    state_d  = state_q;
    pwr_d    = pwr_q;
    gate_d   = gate_q;
    last_d   = last_q;
    cause_d  = cause_q;
    flag_set = 1'b0;
    unique case (state_q)
      ST_AWAKE: begin
        if (rise && permit) begin
          state_d = ST_DOZE;
          pwr_d   = req_mode;
          gate_d  = ck_mode;
          last_d  = ck_mode;
          cause_d = '0;
        end
      end
      ST_DOZE: begin
        if (|wake_evt) begin
          state_d  = ST_AWAKE;
          pwr_d    = '0;
          gate_d   = '0;
          cause_d  = wake_evt;
          flag_set = gate_q[0];
        end
      end
      default: state_d = ST_AWAKE;
    endcase
    flag_d = (flag_q && !flag_clr) || flag_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_AWAKE;
      slp_q   <= 1'b0;
      pwr_q   <= '0;
      gate_q  <= '0;
      last_q  <= '0;
      cause_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      slp_q   <= core_sleeping;
      pwr_q   <= pwr_d;
      gate_q  <= gate_d;
      last_q  <= last_d;
      cause_q <= cause_d;
      flag_q  <= flag_d;
    end
  end

endmodule

// File: rtl/lpm_entry_ctrl.sv
module lpm_entry_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned NUM_MODES = 5,
  parameter int unsigned NUM_WAKE  = 5,
  parameter int unsigned CLK_LVLS  = 3,
  parameter int unsigned DATA_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic                 core_sleeping,
  input  logic [NUM_WAKE-1:0]  wake_evt,
  output logic [NUM_MODES-1:0] pwr_state,
  output logic [CLK_LVLS-1:0]  clk_gate
);

  localparam int unsigned CAUSE_LSB = 1;
  localparam int unsigned LAST_LSB  = CAUSE_LSB + NUM_WAKE;
  localparam int unsigned LOCK_BIT  = DATA_W - 1;

  logic [NUM_MODES-1:0] allow_q, req_mode;
  logic [CLK_LVLS-1:0]  ck_mode, last_ck;
  logic [NUM_WAKE-1:0]  wake_cause;
  logic allow_lock, ck_lock, flag_clr, permit, gated_flag;

  lpm_cfg_regs #(.NUM_MODES(NUM_MODES), .CLK_LVLS(CLK_LVLS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .allow_q(allow_q), .allow_lock(allow_lock), .req_mode(req_mode),
    .ck_mode(ck_mode), .ck_lock(ck_lock), .flag_clr(flag_clr)
  );

  lpm_mode_check #(.NUM_MODES(NUM_MODES)) u_check (
    .allow_q(allow_q), .req_mode(req_mode), .permit(permit)
  );

  lpm_seq #(.NUM_MODES(NUM_MODES), .NUM_WAKE(NUM_WAKE), .CLK_LVLS(CLK_LVLS)) u_seq (
    .clk(clk), .rst_n(rst_n), .core_sleeping(core_sleeping), .wake_evt(wake_evt),
    .permit(permit), .req_mode(req_mode), .ck_mode(ck_mode), .flag_clr(flag_clr),
    .pwr_q(pwr_state), .gate_q(clk_gate), .flag_q(gated_flag),
    .cause_q(wake_cause), .last_q(last_ck)
  );

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_PERMIT: begin
        rdata[NUM_MODES-1:0] = allow_q;
        rdata[LOCK_BIT]      = allow_lock;
      end
      A_PMODE: rdata[NUM_MODES-1:0] = req_mode;
      A_CKMODE: begin
        rdata[CLK_LVLS-1:0] = ck_mode;
        rdata[LOCK_BIT]     = ck_lock;
      end
      default: begin
        rdata[0]                        = gated_flag;
        rdata[CAUSE_LSB +: NUM_WAKE]    = wake_cause;
        rdata[LAST_LSB +: CLK_LVLS]     = last_ck;
      end
    endcase
  end

endmodule

// File: rtl/lpm_entry_ctrl_chk.sv
module lpm_entry_ctrl_chk
  import lpm_pkg::*;
#(
  parameter int unsigned NUM_MODES = 5,
  parameter int unsigned NUM_WAKE  = 5,
  parameter int unsigned CLK_LVLS  = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 core_sleeping,
  input logic [NUM_WAKE-1:0]  wake_evt,
  input logic [NUM_MODES-1:0] pwr_state,
  input logic [CLK_LVLS-1:0]  clk_gate,
  input logic [NUM_MODES-1:0] allow_q,
  input logic                 allow_lock,
  input logic [CLK_LVLS-1:0]  ck_mode,
  input logic                 ck_lock,
  input logic                 gated_flag
);

  p_permit_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    allow_lock |=> ($stable(allow_q) && allow_lock));

  p_clock_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ck_lock |=> ($stable(ck_mode) && ck_lock));

  p_therm_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    therm_ok({{(CHK_W-NUM_MODES){1'b0}}, pwr_state}) &&
    therm_ok({{(CHK_W-CLK_LVLS){1'b0}}, clk_gate}));

  p_stay_awake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == '0 && !core_sleeping) |=> (pwr_state == '0 && clk_gate == '0));

  p_wake_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != '0 && wake_evt != '0) |=> (pwr_state == '0 && clk_gate == '0));

  p_flag_on_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != '0 && wake_evt != '0 && clk_gate[0]) |=> gated_flag);

  p_hold_asleep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != '0 && wake_evt == '0) |=> ($stable(pwr_state) && $stable(clk_gate)));

endmodule

bind lpm_entry_ctrl lpm_entry_ctrl_chk #(
  .NUM_MODES(NUM_MODES), .NUM_WAKE(NUM_WAKE), .CLK_LVLS(CLK_LVLS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .core_sleeping(core_sleeping), .wake_evt(wake_evt),
  .pwr_state(pwr_state), .clk_gate(clk_gate), .allow_q(allow_q),
  .allow_lock(allow_lock), .ck_mode(ck_mode), .ck_lock(ck_lock),
  .gated_flag(gated_flag)
);

// File: tb/lpm_entry_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_entry_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        core_sleeping = 1'b0;
  logic [4:0]  wake_evt = 5'd0;
  logic [4:0]  pwr_state;
  logic [2:0]  clk_gate;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic       exp_flag;
  logic [4:0] exp_cause;
  logic [2:0] exp_last;

  always #10 clk = ~clk;

  lpm_entry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .core_sleeping(core_sleeping), .wake_evt(wake_evt),
    .pwr_state(pwr_state), .clk_gate(clk_gate)
  );

  function automatic logic f_permit(input logic [4:0] allow, input logic [4:0] mode);
    for (int i = 0; i < 5; i++)
      if (mode == 5'((1 << (i + 1)) - 1)) return allow[i];
    return 1'b0;
  endfunction

  function automatic logic [15:0] f_status(input logic fl, input logic [4:0] c, input logic [2:0] l);
    return {7'd0, l, c, fl};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [15:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic chk_out(input string req, input logic [4:0] p, input logic [2:0] g);
    check(req, {11'd0, pwr_state}, {11'd0, p});
    check(req, {13'd0, clk_gate}, {13'd0, g});
  endtask

  // raise sleeping at a falling edge; outputs are checked one edge later
  task automatic enter_sleep();
    @(negedge clk); core_sleeping = 1'b1;
    @(negedge clk);
  endtask

  task automatic wake(input logic [4:0] w);
    wake_evt = w;
    @(negedge clk); wake_evt = 5'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd("R1", 2'd0, 16'h0000); rd("R1", 2'd1, 16'h0000);
    rd("R1", 2'd2, 16'h0000); rd("R1", 2'd3, 16'h0000);
    chk_out("R1", 5'd0, 3'd0);
    exp_flag = 1'b0; exp_cause = 5'd0; exp_last = 3'd0;

    // R2 permission write, R4 code filtering
    wr(2'd0, 16'h001F); rd("R2", 2'd0, 16'h001F);
    wr(2'd1, 16'h0003); rd("R4", 2'd1, 16'h0003);
    wr(2'd1, 16'h0005); rd("R4 non-thermometer mode ignored", 2'd1, 16'h0003);
    wr(2'd2, 16'h0003); wr(2'd2, 16'h0002);
    rd("R4 non-thermometer clock ignored", 2'd2, 16'h0003);

    // R5 entry, R10 last clock mode
    enter_sleep();
    chk_out("R5", 5'h03, 3'h3);
    rd("R10", 2'd3, f_status(1'b0, 5'd0, 3'd3));
    // R11 writes while asleep leave the outputs alone
    wr(2'd2, 16'h0007); wr(2'd1, 16'h001F);
    chk_out("R11", 5'h03, 3'h3);
    // R8 wake, R9 flag
    wake(5'h04);
    chk_out("R8", 5'd0, 3'd0);
    rd("R8 R9", 2'd3, f_status(1'b1, 5'h04, 3'd3));
    // R7 level held high: no re-entry
    repeat (3) @(negedge clk);
    chk_out("R7", 5'd0, 3'd0);
    core_sleeping = 1'b0;
    wr(2'd3, 16'h0001);
    rd("R9 clear", 2'd3, f_status(1'b0, 5'h04, 3'd3));

    // R9 collision: wake sets flag in same cycle as software clear
    enter_sleep();
    chk_out("R5 hold", 5'h1F, 3'h7);
    rd("R8 cause cleared at entry", 2'd3, f_status(1'b0, 5'd0, 3'd7));
    wake_evt = 5'h11; wr_en = 1'b1; addr = 2'd3; wdata = 16'h0001;
    @(negedge clk); wake_evt = 5'd0; wr_en = 1'b0;
    rd("R9 set beats clear", 2'd3, f_status(1'b1, 5'h11, 3'd7));
    core_sleeping = 1'b0;
    wr(2'd3, 16'h0001);

    // R6 refusals: mode not permitted, and Active
    wr(2'd0, 16'h0001); wr(2'd1, 16'h0007); wr(2'd2, 16'h0001);
    enter_sleep();
    chk_out("R6 not permitted", 5'd0, 3'd0);
    rd("R10 unchanged on refusal", 2'd3, f_status(1'b0, 5'h11, 3'd7));
    core_sleeping = 1'b0;
    wr(2'd1, 16'h0000);
    enter_sleep();
    chk_out("R6 active", 5'd0, 3'd0);
    core_sleeping = 1'b0;
    exp_cause = 5'h11; exp_last = 3'd7;

    // random mix against the model
    for (int it = 0; it < 60; it++) begin
      logic [4:0] a, m, w;
      logic [2:0] c;
      logic perm;
      a = 5'($urandom);
      m = 5'((1 << ($urandom % 6)) - 1);
      c = 3'((1 << ($urandom % 4)) - 1);
      w = 5'(($urandom % 31) + 1);
      perm = f_permit(a, m);
      wr(2'd0, {11'd0, a}); wr(2'd1, {11'd0, m}); wr(2'd2, {13'd0, c});
      wr(2'd3, 16'h0001);
      exp_flag = 1'b0;
      enter_sleep();
      chk_out(perm ? "R5 random" : "R6 random", perm ? m : 5'd0, perm ? c : 3'd0);
      if (perm) begin
        wake(w);
        chk_out("R8 random", 5'd0, 3'd0);
        exp_cause = w; exp_flag = c[0]; exp_last = c;
      end
      rd("R9 R10 random", 2'd3, f_status(exp_flag, exp_cause, exp_last));
      core_sleeping = 1'b0;
    end

    // R2 lock on permissions
    wr(2'd0, 16'h8003); wr(2'd0, 16'h001F);
    rd("R2 locked", 2'd0, 16'h8003);
    wr(2'd0, 16'h0000);
    rd("R2 lock not clearable", 2'd0, 16'h8003);
    // R3 lock on clock mode
    wr(2'd2, 16'h8001); wr(2'd2, 16'h0007);
    rd("R3 locked", 2'd2, 16'h8001);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule